// File: doc/BRIEF.md
# Protection Entry Configuration Register File

This block stores the settings of a set of physical memory protection entries: one 8-bit configuration byte and one address word per entry, plus a three-bit machine security control register. Software writes arrive as already decoded requests. A configuration write carries a packed word that updates several entries at once. An address write targets a single entry. A security write updates the control flags. Each request is filtered through the lock, reserved-encoding and sticky-flag rules before anything is stored.

The stored arrays drive flat output buses, and a region decoder further down the pipeline reads them. A one-cycle `changed` pulse follows every write that really alters protection state, so that translation or permission caches downstream know to flush. Two read ports return one packed configuration word and one address word, each one cycle after the index is presented.

Top module: `pmp_cfg_regfile`

## Requirements
- R1: After a synchronous reset, every configuration byte, every address word, all three security flags and `changed` are 0.
- R2: A configuration write to word k stores byte lane i (bits 8i+7:8i) of the data in entry 4k+i. Inside the byte, bit 0 is read, bit 1 is write, bit 2 is execute, bits 4:3 select the match mode (0 off, 1 top-of-range, 2 four-byte, 3 power-of-two) and bit 7 is lock.
- R3: While the lockdown flag is clear, a configuration byte whose write bit is 1 and read bit is 0 is discarded and that entry keeps its old value. While lockdown is set, such a byte is accepted.
- R4: `changed` is high for exactly the one cycle after a write that alters a stored byte, a stored address, the lockdown flag or the whitelist flag. A write that leaves all of these unchanged, including one that changes only the bypass flag, gives no pulse.
- R5: An entry counts as locked when its lock bit is set and the bypass flag is clear. A configuration write or an address write to a locked entry is ignored while lockdown is clear.
- R6: An address write to entry j is ignored when entry j+1 is locked and in top-of-range mode. A locked neighbour in any other mode does not block it.
- R7: The bypass flag cannot go from 0 to 1 while any entry holds its lock bit.
- R8: While the bypass flag is set, no entry counts as locked, so configuration and address writes to entries with the lock bit set are accepted.
- R9: While lockdown is set, a configuration write to a locked entry is accepted only if the new byte sets lock with execute clear, or leaves lock clear and its low three bits are not exactly write+execute (binary 110).
- R10: Security write data bit 0 is lockdown, bit 1 is whitelist and bit 2 is bypass. Lockdown and whitelist are sticky: once set, a write cannot clear them until reset.
- R11: A configuration word whose entries all lie at N_ENTRIES or above, and an address index at N_ENTRIES or above, are ignored, and reads of them return 0.
- R12: The read ports return the addressed configuration word and address word one clock after the index is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration word write request |
| cfg_widx | input | IDX_W | Configuration word index |
| cfg_wdata | input | XLEN | Packed configuration bytes |
| addr_we | input | 1 | Address write request |
| addr_widx | input | IDX_W | Entry index of the address write |
| addr_wdata | input | XLEN | New address value |
| sec_we | input | 1 | Security control write request |
| sec_wdata | input | 3 | {bypass, whitelist, lockdown} |
| rd_cfg_idx | input | IDX_W | Configuration word read index |
| rd_cfg_data | output | XLEN | Registered configuration word read data |
| rd_addr_idx | input | IDX_W | Address read index |
| rd_addr_data | output | XLEN | Registered address read data |
| cfg_flat | output | 8*N_ENTRIES | All configuration bytes, entry e at bits 8e+7:8e |
| addr_flat | output | XLEN*N_ENTRIES | All address words, entry e at slice e |
| sec_mml | output | 1 | Lockdown flag |
| sec_mmwp | output | 1 | Whitelist flag |
| sec_rlb | output | 1 | Lock bypass flag |
| changed | output | 1 | One-cycle flush pulse |

## Verification
The hardest state to reach is a locked entry that is evaluated under lockdown. Lockdown is sticky and the bypass flag cannot be raised once a lock exists, so the order of writes decides which cases are reachable. The bench resets before each scenario. In the lockdown scenario it sets lockdown first, then places an unlocked entry into the locked state, and then tries each class of byte against it: lock with execute, lock without execute, write+execute without lock, and another unlocked encoding. It confirms each outcome on the flat bus and on the `changed` pulse. The address-blocking rule is reached by locking the neighbour entry in top-of-range mode and then in four-byte mode.

// File: rtl/pmp_rf_pkg.sv
package pmp_rf_pkg;
  localparam int BIT_R = 0;
  localparam int BIT_W = 1;
  localparam int BIT_X = 2;
  localparam int BIT_L = 7;
  localparam int AM_LO = 3;

  typedef enum logic [1:0] {
    AM_OFF   = 2'd0,
    AM_TOR   = 2'd1,
    AM_NA4   = 2'd2,
    AM_NAPOT = 2'd3
  } amode_e;

  function automatic logic cfg_locked(input logic [7:0] c, input logic bypass);
    return c[BIT_L] & ~bypass;
  endfunction

  function automatic amode_e cfg_mode(input logic [7:0] c);
    return amode_e'(c[AM_LO +: 2]);
  endfunction
endpackage

// File: rtl/pmp_cfg_lane.sv
module pmp_cfg_lane
  import pmp_rf_pkg::*;
(
  input  logic [7:0] cur_cfg,
  input  logic       sel,
  input  logic [7:0] new_cfg,
  input  logic       bypass,
  input  logic       lockdown,
  output logic       upd
);
  logic own_lock;
  logic lockdown_ok;
  logic reserved;

  always_comb begin
    own_lock    = cfg_locked(cur_cfg, bypass);
    // Under lockdown a locked entry takes a new locked rule without execute,
    // or an unlocked rule that is not the write+execute shared encoding.
    lockdown_ok = lockdown &&
                  ((new_cfg[BIT_L] && !new_cfg[BIT_X]) ||
                   (!new_cfg[BIT_L] && (new_cfg[2:0] != 3'b110)));
    reserved    = !lockdown && new_cfg[BIT_W] && !new_cfg[BIT_R];
    upd         = sel && (!own_lock || lockdown_ok) && !reserved &&
                  (new_cfg != cur_cfg);
  end
endmodule

// File: rtl/pmp_addr_lane.sv
module pmp_addr_lane #(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] cur_addr,
  input  logic            sel,
  input  logic [XLEN-1:0] new_addr,
  input  logic            own_lock,
  input  logic            next_tor_lock,
  output logic            upd
);
  always_comb
    upd = sel && !own_lock && !next_tor_lock && (new_addr != cur_addr);
endmodule

// File: rtl/pmp_sec_reg.sv
module pmp_sec_reg (
  input  logic       clk,
  input  logic       rst,
  input  logic       we,
  input  logic [2:0] wdata,
  input  logic       any_locked,
  output logic       mml,
  output logic       mmwp,
  output logic       rlb,
  output logic       sticky_chg
);
  logic nxt_mml, nxt_mmwp, nxt_rlb;

  always_comb begin
    nxt_mml    = mml | wdata[0];
    nxt_mmwp   = mmwp | wdata[1];
    nxt_rlb    = wdata[2] & (rlb | ~any_locked);
    sticky_chg = we && ((nxt_mml != mml) || (nxt_mmwp != mmwp));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mml  <= 1'b0;
      mmwp <= 1'b0;
      rlb  <= 1'b0;
    end else if (we) begin
      mml  <= nxt_mml;
      mmwp <= nxt_mmwp;
      rlb  <= nxt_rlb;
    end
  end
endmodule

// File: rtl/pmp_cfg_regfile.sv
module pmp_cfg_regfile
  import pmp_rf_pkg::*;
#(
  parameter int N_ENTRIES = 8,
  parameter int XLEN      = 32,
  parameter int IDX_W     = 4
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      cfg_we,
  input  logic [IDX_W-1:0]          cfg_widx,
  input  logic [XLEN-1:0]           cfg_wdata,
  input  logic                      addr_we,
  input  logic [IDX_W-1:0]          addr_widx,
  input  logic [XLEN-1:0]           addr_wdata,
  input  logic                      sec_we,
  input  logic [2:0]                sec_wdata,
  input  logic [IDX_W-1:0]          rd_cfg_idx,
  output logic [XLEN-1:0]           rd_cfg_data,
  input  logic [IDX_W-1:0]          rd_addr_idx,
  output logic [XLEN-1:0]           rd_addr_data,
  output logic [8*N_ENTRIES-1:0]    cfg_flat,
  output logic [XLEN*N_ENTRIES-1:0] addr_flat,
  output logic                      sec_mml,
  output logic                      sec_mmwp,
  output logic                      sec_rlb,
  output logic                      changed
);
  localparam int BPW = XLEN / 8;

  logic [N_ENTRIES-1:0][7:0]      cfg_q;
  logic [N_ENTRIES-1:0][XLEN-1:0] addr_q;
  logic [N_ENTRIES-1:0][7:0]      cfg_new;
  logic [N_ENTRIES-1:0]           cfg_sel, cfg_upd;
  logic [N_ENTRIES-1:0]           addr_sel, addr_upd;
  logic [N_ENTRIES-1:0]           own_lock, next_tor_lock;
  logic                           any_locked, sticky_chg;

  // Route packed word lanes to entries: lane i of word k feeds entry 4k+i.
  always_comb begin
    for (int e = 0; e < N_ENTRIES; e++) begin
      automatic int base = int'(cfg_widx) * 4;
      cfg_sel[e]  = cfg_we && (e >= base) && (e < base + BPW);
      cfg_new[e]  = cfg_sel[e] ? cfg_wdata[8*(e-base) +: 8] : 8'h00;
      addr_sel[e] = addr_we && (int'(addr_widx) == e);
      own_lock[e] = cfg_locked(cfg_q[e], sec_rlb);
    end
    any_locked = |own_lock;
  end

  for (genvar e = 0; e < N_ENTRIES; e++) begin : g_ent
    if (e + 1 < N_ENTRIES) begin : g_nxt
      assign next_tor_lock[e] = own_lock[e+1] && (cfg_mode(cfg_q[e+1]) == AM_TOR);
    end else begin : g_top
      assign next_tor_lock[e] = 1'b0;
    end

    pmp_cfg_lane u_cfg (
      .cur_cfg  (cfg_q[e]),
      .sel      (cfg_sel[e]),
      .new_cfg  (cfg_new[e]),
      .bypass   (sec_rlb),
      .lockdown (sec_mml),
      .upd      (cfg_upd[e])
    );

    pmp_addr_lane #(.XLEN(XLEN)) u_addr (
      .cur_addr      (addr_q[e]),
      .sel           (addr_sel[e]),
      .new_addr      (addr_wdata),
      .own_lock      (own_lock[e]),
      .next_tor_lock (next_tor_lock[e]),
      .upd           (addr_upd[e])
    );

    assign cfg_flat[8*e +: 8]        = cfg_q[e];
    assign addr_flat[XLEN*e +: XLEN] = addr_q[e];
  end

  pmp_sec_reg u_sec (
    .clk        (clk),
    .rst        (rst),
    .we         (sec_we),
    .wdata      (sec_wdata),
    .any_locked (any_locked),
    .mml        (sec_mml),
    .mmwp       (sec_mmwp),
    .rlb        (sec_rlb),
    .sticky_chg (sticky_chg)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q   <= '0;
      addr_q  <= '0;
      changed <= 1'b0;
    end else begin
      for (int e = 0; e < N_ENTRIES; e++) begin
        if (cfg_upd[e])  cfg_q[e]  <= cfg_new[e];
        if (addr_upd[e]) addr_q[e] <= addr_wdata;
      end
      changed <= (|cfg_upd) | (|addr_upd) | sticky_chg;
    end
  end

  // Registered read ports; indices past the last entry read as zero.
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_cfg_data  <= '0;
      rd_addr_data <= '0;
    end else begin
      for (int i = 0; i < BPW; i++) begin
        automatic int ent = int'(rd_cfg_idx) * 4 + i;
        rd_cfg_data[8*i +: 8] <= (ent < N_ENTRIES) ? cfg_q[ent] : 8'h00;
      end
      rd_addr_data <= (int'(rd_addr_idx) < N_ENTRIES) ? addr_q[rd_addr_idx] : '0;
    end
  end
endmodule

// File: rtl/pmp_cfg_regfile_chk.sv
module pmp_cfg_regfile_chk #(
  parameter int N_ENTRIES = 8,
  parameter int XLEN      = 32,
  parameter int IDX_W     = 4
) (
  input logic                      clk,
  input logic                      rst,
  input logic                      cfg_we,
  input logic                      addr_we,
  input logic                      sec_we,
  input logic [8*N_ENTRIES-1:0]    cfg_flat,
  input logic [XLEN*N_ENTRIES-1:0] addr_flat,
  input logic                      sec_mml,
  input logic                      sec_mmwp,
  input logic                      sec_rlb,
  input logic                      changed
);
  logic any_l, any_reserved;

  always_comb begin
    any_l = 1'b0;
    any_reserved = 1'b0;
    for (int e = 0; e < N_ENTRIES; e++) begin
      any_l        = any_l | cfg_flat[8*e+7];
      any_reserved = any_reserved | (cfg_flat[8*e+1] & ~cfg_flat[8*e]);
    end
  end

  a_r10_mml_sticky: assert property (@(posedge clk) disable iff (rst)
    sec_mml |=> sec_mml);
  a_r10_mmwp_sticky: assert property (@(posedge clk) disable iff (rst)
    sec_mmwp |=> sec_mmwp);
  a_r7_rlb_rise: assert property (@(posedge clk) disable iff (rst)
    $rose(sec_rlb) |-> !$past(any_l));
  a_r3_no_reserved: assert property (@(posedge clk) disable iff (rst)
    !sec_mml |-> !any_reserved);
  a_r4_changed_cause: assert property (@(posedge clk) disable iff (rst)
    changed |-> $past(cfg_we || addr_we || sec_we));

  for (genvar e = 0; e < N_ENTRIES; e++) begin : g_chk
    a_r5_cfg_lock_hold: assert property (@(posedge clk) disable iff (rst)
      (!sec_mml && !sec_rlb && cfg_flat[8*e+7]) |=> $stable(cfg_flat[8*e +: 8]));
    a_r5_addr_lock_hold: assert property (@(posedge clk) disable iff (rst)
      (!sec_rlb && cfg_flat[8*e+7]) |=> $stable(addr_flat[XLEN*e +: XLEN]));
  end
endmodule

bind pmp_cfg_regfile pmp_cfg_regfile_chk #(
  .N_ENTRIES(N_ENTRIES), .XLEN(XLEN), .IDX_W(IDX_W)
) u_chk (
  .clk(clk), .rst(rst), .cfg_we(cfg_we), .addr_we(addr_we), .sec_we(sec_we),
  .cfg_flat(cfg_flat), .addr_flat(addr_flat), .sec_mml(sec_mml),
  .sec_mmwp(sec_mmwp), .sec_rlb(sec_rlb), .changed(changed)
);

// File: tb/pmp_cfg_regfile_test.sv
`timescale 1ns/1ps
module pmp_cfg_regfile_test;
  localparam int N = 8;
  localparam int XL = 32;
  localparam int IW = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_we = 1'b0, addr_we = 1'b0, sec_we = 1'b0;
  logic [IW-1:0] cfg_widx = '0, addr_widx = '0, rd_cfg_idx = '0, rd_addr_idx = '0;
  logic [XL-1:0] cfg_wdata = '0, addr_wdata = '0;
  logic [2:0] sec_wdata = '0;
  logic [XL-1:0] rd_cfg_data, rd_addr_data;
  logic [8*N-1:0] cfg_flat;
  logic [XL*N-1:0] addr_flat;
  logic sec_mml, sec_mmwp, sec_rlb, changed;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  pmp_cfg_regfile #(.N_ENTRIES(N), .XLEN(XL), .IDX_W(IW)) uut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_widx(cfg_widx), .cfg_wdata(cfg_wdata),
    .addr_we(addr_we), .addr_widx(addr_widx), .addr_wdata(addr_wdata),
    .sec_we(sec_we), .sec_wdata(sec_wdata), .rd_cfg_idx(rd_cfg_idx),
    .rd_cfg_data(rd_cfg_data), .rd_addr_idx(rd_addr_idx), .rd_addr_data(rd_addr_data),
    .cfg_flat(cfg_flat), .addr_flat(addr_flat), .sec_mml(sec_mml),
    .sec_mmwp(sec_mmwp), .sec_rlb(sec_rlb), .changed(changed)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    @(negedge clk); @(negedge clk); rst = 1'b0;
  endtask

  task automatic wr_cfg(input int w, input logic [XL-1:0] d);
    @(negedge clk); cfg_we = 1'b1; cfg_widx = IW'(w); cfg_wdata = d;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic wr_addr(input int i, input logic [XL-1:0] d);
    @(negedge clk); addr_we = 1'b1; addr_widx = IW'(i); addr_wdata = d;
    @(negedge clk); addr_we = 1'b0;
  endtask

  task automatic wr_sec(input logic [2:0] d);
    @(negedge clk); sec_we = 1'b1; sec_wdata = d;
    @(negedge clk); sec_we = 1'b0;
  endtask

  function automatic logic [XL-1:0] addr_of(input int e);
    return addr_flat[XL*e +: XL];
  endfunction

  task automatic t_reset();
    do_reset();
    chk("R1 cfg", cfg_flat, 64'h0);
    chk("R1 addr", addr_flat[63:0], 64'h0);
    chk("R1 flags", {sec_rlb, sec_mmwp, sec_mml}, 3'b000);
    chk("R1 changed", changed, 1'b0);
  endtask

  task automatic t_pack();
    do_reset();
    wr_cfg(0, 32'h0D0B0903);
    chk("R4 pulse", changed, 1'b1);
    chk("R2 word0", cfg_flat[31:0], 32'h0D0B0903);
    @(negedge clk);
    chk("R4 one cycle", changed, 1'b0);
    wr_cfg(1, 32'h1F191100);
    chk("R2 word1", cfg_flat[63:32], 32'h1F191100);
    rd_cfg_idx = IW'(1);
    @(negedge clk);
    chk("R12 cfg read", rd_cfg_data, 32'h1F191100);
    wr_cfg(1, 32'h1F191100);
    chk("R4 same value no pulse", changed, 1'b0);
  endtask

  task automatic t_reserved();
    do_reset();
    wr_cfg(0, 32'h01020302);
    chk("R3 reserved dropped", cfg_flat[31:0], 32'h01000300);
  endtask

  task automatic t_lock();
    do_reset();
    wr_addr(3, 32'h100);
    wr_cfg(0, 32'h81000000);
    wr_cfg(0, 32'h07000000);
    chk("R5 cfg locked", cfg_flat[31:0], 32'h81000000);
    chk("R5 no pulse", changed, 1'b0);
    wr_addr(3, 32'h200);
    chk("R5 addr locked", addr_of(3), 32'h100);
    wr_cfg(0, 32'h81000003);
    chk("R5 unlocked neighbour", cfg_flat[31:0], 32'h81000003);
  endtask

  task automatic t_tor();
    do_reset();
    wr_cfg(0, 32'h00000900);
    wr_addr(0, 32'h40);
    chk("R6 unlocked tor", addr_of(0), 32'h40);
    wr_cfg(0, 32'h00008900);
    wr_addr(0, 32'h80);
    chk("R6 locked tor blocks", addr_of(0), 32'h40);
    wr_cfg(0, 32'h91008900);
    wr_addr(2, 32'h55);
    chk("R6 na4 neighbour allows", addr_of(2), 32'h55);
  endtask

  task automatic t_rlb();
    do_reset();
    wr_cfg(0, 32'h00000081);
    wr_sec(3'b100);
    chk("R7 bypass refused", sec_rlb, 1'b0);
    chk("R4 no pulse", changed, 1'b0);
    do_reset();
    wr_sec(3'b100);
    chk("R8 bypass set", sec_rlb, 1'b1);
    chk("R4 bypass only no pulse", changed, 1'b0);
    wr_cfg(0, 32'h00000081);
    wr_cfg(0, 32'h00000003);
    chk("R8 cfg bypass", cfg_flat[31:0], 32'h00000003);
    wr_cfg(0, 32'h00000081);
    wr_addr(0, 32'h7);
    chk("R8 addr bypass", addr_of(0), 32'h7);
  endtask

  task automatic t_mml();
    do_reset();
    wr_sec(3'b001);
    chk("R10 mml set", sec_mml, 1'b1);
    chk("R4 mml pulse", changed, 1'b1);
    wr_cfg(0, 32'h00000002);
    chk("R3 accepted under lockdown", cfg_flat[31:0], 32'h00000002);
    wr_cfg(0, 32'h00008102);
    wr_cfg(0, 32'h00008502);
    chk("R9 lock+exec refused", cfg_flat[31:0], 32'h00008102);
    chk("R9 no pulse", changed, 1'b0);
    wr_cfg(0, 32'h00008302);
    chk("R9 lock no exec ok", cfg_flat[31:0], 32'h00008302);
    wr_cfg(0, 32'h00000602);
    chk("R9 shared wx refused", cfg_flat[31:0], 32'h00008302);
    wr_cfg(0, 32'h00000502);
    chk("R9 unlocked rx ok", cfg_flat[31:0], 32'h00000502);
  endtask

  task automatic t_sticky();
    do_reset();
    wr_sec(3'b010);
    chk("R10 mmwp set", sec_mmwp, 1'b1);
    chk("R4 mmwp pulse", changed, 1'b1);
    wr_sec(3'b000);
    chk("R10 mmwp sticky", sec_mmwp, 1'b1);
    chk("R4 no change no pulse", changed, 1'b0);
    wr_sec(3'b001);
    wr_sec(3'b000);
    chk("R10 both sticky", {sec_mmwp, sec_mml}, 2'b11);
  endtask

  task automatic t_oob();
    do_reset();
    wr_cfg(0, 32'h00000101);
    wr_addr(5, 32'hDEADBEEF);
    chk("R4 addr pulse", changed, 1'b1);
    rd_addr_idx = IW'(5);
    @(negedge clk);
    chk("R12 addr read", rd_addr_data, 32'hDEADBEEF);
    wr_cfg(2, 32'hFFFFFFFF);
    chk("R11 cfg oob", cfg_flat, 64'h0000000000000101);
    chk("R11 cfg oob no pulse", changed, 1'b0);
    wr_addr(9, 32'h123);
    chk("R11 addr oob no pulse", changed, 1'b0);
    rd_cfg_idx = IW'(2);
    rd_addr_idx = IW'(9);
    @(negedge clk);
    chk("R11 cfg oob read", rd_cfg_data, 32'h0);
    chk("R11 addr oob read", rd_addr_data, 32'h0);
    chk("R11 addr intact", addr_of(5), 32'hDEADBEEF);
  endtask

  initial begin
    t_reset();
    t_pack();
    t_reserved();
    t_lock();
    t_tor();
    t_rlb();
    t_mml();
    t_sticky();
    t_oob();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #50000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule